// File: doc/BRIEF.md
# Indirect Register Bridge for an 8-bit Microcontroller SFR Port

This bridge lets an 8-bit microcontroller reach a peripheral with a 9-bit register address space through only four slots of its external special-function-register port. The slot address is 7 bits wide: it is the 8-bit SFR address with its top bit dropped, so the slots at 0x40 to 0x43 appear here as 7'h40 to 7'h43. Firmware first sets a target address in two slots. It then either writes a byte into the write-data slot, which forwards it to the peripheral, or sets a request bit, which starts a peripheral read. The result is returned through the read-data slot. The bridge, the host and the peripheral all run on one clock.

The peripheral address places a channel number (0 to 15) in bits [8:5], a transmit/receive select in bit [4], a register index in bits [3:2] and a byte index in bits [1:0]. The low address slot holds address bits [7:0]. The high address slot uses bit 0 for address bit [8]. Its remaining seven bits serve as control and status: bit 1 requests a read, bit 2 reports busy, bit 3 reports done, and bits [7:4] are unused.

A single controller sequences every transfer. It has five states:
- ST_IDLE waits for a host request.
- ST_WRITE drives the peripheral write strobe for one cycle.
- ST_READ drives the peripheral read strobe for one cycle.
- ST_WAIT counts out the rest of the peripheral's fixed read latency.
- ST_LATCH captures the returned byte.

It has six transitions:
- IDLE to WRITE on an accepted write-data store.
- IDLE to READ on an accepted read request.
- WRITE to IDLE after one cycle.
- READ to WAIT, or READ straight to LATCH when the latency is one cycle.
- WAIT to LATCH when its counter reaches zero.
- LATCH to IDLE after one cycle.

Top module: `sfr_ind_bridge`

## Requirements
- R1: After reset, the peripheral address, the write-data byte and the read-data byte are all 0. Both peripheral strobes are low, and the control slot reads 0 (not busy, not done).
- R2: sfr_hit is high only when sfr_addr equals SFR_BASE+0..3 (default 7'h40..7'h43). For any other address sfr_rdata is 0, and host writes there change no bridge state.
- R3: A write to slot 0 sets per_addr[7:0]. A write to slot 1 sets per_addr[8] from its bit 0. per_addr presents channel[8:5], tx/rx[4], register index[3:2] and byte index[1:0] exactly as written. Slot 0 reads back per_addr[7:0].
- R4: A host write to slot 2 while idle raises per_wr in the following cycle with per_wdata equal to the written byte and per_addr equal to the current address. Slot 2 reads back that byte.
- R5: A host write to slot 1 with bit 1 set while idle raises per_rd in the following cycle. The byte on per_rdata exactly RD_LAT cycles after the per_rd cycle is stored and returned by slot 3, and done is set in the same cycle.
- R6: Reading slot 1 returns address bit 8 in bit 0, 0 in bit 1, busy in bit 2, done in bit 3, and 0 in bits [7:4].
- R7: Busy is high from the cycle after a request is accepted until the transfer ends (1 cycle for a write, RD_LAT+1 cycles for a read). While busy, host writes to any slot are ignored: no strobe is issued, the address stays unchanged, and slot 2 keeps its value.
- R8: Any accepted host write to slot 1 clears done.
- R9: Host writes to slot 3 have no effect on its contents.
- R10: per_wr and per_rd are never high together, and each stays high for only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 7 | Host external SFR address (8-bit address with MSB dropped) |
| sfr_wr | input | 1 | Host SFR write strobe |
| sfr_wdata | input | 8 | Host SFR write data |
| sfr_rdata | output | 8 | Readback of the addressed slot, 0 when not decoded |
| sfr_hit | output | 1 | High when sfr_addr selects one of the four slots |
| per_addr | output | 9 | Assembled peripheral register address |
| per_wdata | output | 8 | Byte forwarded to the peripheral |
| per_wr | output | 1 | One-cycle peripheral write strobe |
| per_rd | output | 1 | One-cycle peripheral read strobe |
| per_rdata | input | 8 | Peripheral read data, valid RD_LAT cycles after per_rd |

## Verification
The bench keeps the default SFR_BASE of 7'h40 and the default SFR_ADDR_W of 7, so real firmware slot numbers are used. It builds the bridge with RD_LAT set to 3 rather than the default of 2. This makes ST_WAIT last two cycles, so the counter is exercised beyond a single step. It also leaves a window in the middle of a read in which a stray host write can be tested for rejection. The peripheral model returns a poison byte in every cycle except the one where its data is valid, so a capture one cycle early or late shows up as a wrong value in slot 3.

// File: rtl/sfr_bridge_pkg.sv
package sfr_bridge_pkg;

    localparam int DATA_W     = 8;
    localparam int PER_ADDR_W = 9;
    localparam int HI_BITS    = PER_ADDR_W - DATA_W;
    localparam int NUM_SLOTS  = 4;

    // slot offsets from the base address
    localparam int SLOT_ALO  = 0;
    localparam int SLOT_AHI  = 1;
    localparam int SLOT_WDAT = 2;
    localparam int SLOT_RDAT = 3;

    // bit positions inside the high address / control slot
    localparam int CTL_REQ  = 1;
    localparam int CTL_BUSY = 2;
    localparam int CTL_DONE = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_WAIT,
        ST_LATCH
    } brg_state_e;

endpackage

// File: rtl/sfr_slot_decode.sv
module sfr_slot_decode
    import sfr_bridge_pkg::*;
#(
    parameter int                    SFR_ADDR_W = 7,
    parameter logic [SFR_ADDR_W-1:0] SFR_BASE   = 7'h40
) (
    input  logic [SFR_ADDR_W-1:0] sfr_addr,
    output logic [NUM_SLOTS-1:0]  slot_hit
);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign slot_hit[k] = (sfr_addr == SFR_ADDR_W'(SFR_BASE + k));
    end

endmodule

// File: rtl/sfr_bridge_fsm.sv
module sfr_bridge_fsm
    import sfr_bridge_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic rd_go,
    output logic per_wr,
    output logic per_rd,
    output logic capture,
    output logic busy
);

    localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((RD_LAT > 1) ? RD_LAT - 2 : 0);

    brg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_go)      state_d = ST_WRITE;
                else if (rd_go) state_d = ST_READ;
            end
            ST_WRITE: state_d = ST_IDLE;
            ST_READ:  state_d = (RD_LAT == 1) ? ST_LATCH : ST_WAIT;
            ST_WAIT:  if (cnt_q == '0) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_READ)
                cnt_q <= CNT_LOAD;
            else if (state_q == ST_WAIT && cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // outputs per state
    always_comb begin
        per_wr  = 1'b0;
        per_rd  = 1'b0;
        capture = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy    = 1'b0;
            ST_WRITE: per_wr  = 1'b1;
            ST_READ:  per_rd  = 1'b1;
            ST_WAIT:  ;
            ST_LATCH: capture = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfr_bridge_regs.sv
module sfr_bridge_regs
    import sfr_bridge_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sfr_wr,
    input  logic [NUM_SLOTS-1:0]  slot_hit,
    input  logic [DATA_W-1:0]     sfr_wdata,
    input  logic                  busy,
    input  logic                  capture,
    input  logic [DATA_W-1:0]     per_rdata,
    output logic [PER_ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0]     wdata_q,
    output logic [DATA_W-1:0]     sfr_rdata
);

    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              accept;
    logic [DATA_W-1:0] ctl_view;

    assign accept = sfr_wr && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept && slot_hit[SLOT_ALO])
                addr_q[DATA_W-1:0] <= sfr_wdata;
            if (accept && slot_hit[SLOT_AHI]) begin
                addr_q[PER_ADDR_W-1:DATA_W] <= sfr_wdata[HI_BITS-1:0];
                done_q <= 1'b0;
            end
            if (accept && slot_hit[SLOT_WDAT])
                wdata_q <= sfr_wdata;
            if (capture) begin
                rdata_q <= per_rdata;
                done_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        ctl_view = '0;
        ctl_view[HI_BITS-1:0] = addr_q[PER_ADDR_W-1:DATA_W];
        ctl_view[CTL_BUSY]    = busy;
        ctl_view[CTL_DONE]    = done_q;
    end

    always_comb begin
        sfr_rdata = '0;
        if (slot_hit[SLOT_ALO])  sfr_rdata = addr_q[DATA_W-1:0];
        if (slot_hit[SLOT_AHI])  sfr_rdata = ctl_view;
        if (slot_hit[SLOT_WDAT]) sfr_rdata = wdata_q;
        if (slot_hit[SLOT_RDAT]) sfr_rdata = rdata_q;
    end

endmodule

// File: rtl/sfr_ind_bridge.sv
module sfr_ind_bridge
    import sfr_bridge_pkg::*;
#(
    parameter int                    SFR_ADDR_W = 7,
    parameter logic [SFR_ADDR_W-1:0] SFR_BASE   = 7'h40,
    parameter int                    RD_LAT     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SFR_ADDR_W-1:0] sfr_addr,
    input  logic                  sfr_wr,
    input  logic [DATA_W-1:0]     sfr_wdata,
    output logic [DATA_W-1:0]     sfr_rdata,
    output logic                  sfr_hit,
    output logic [PER_ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0]     per_wdata,
    output logic                  per_wr,
    output logic                  per_rd,
    input  logic [DATA_W-1:0]     per_rdata
);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 busy;
    logic                 capture;
    logic                 wr_go;
    logic                 rd_go;

    sfr_slot_decode #(
        .SFR_ADDR_W (SFR_ADDR_W),
        .SFR_BASE   (SFR_BASE)
    ) u_dec (
        .sfr_addr (sfr_addr),
        .slot_hit (slot_hit)
    );

    assign sfr_hit = |slot_hit;
    assign wr_go   = sfr_wr && slot_hit[SLOT_WDAT];
    assign rd_go   = sfr_wr && slot_hit[SLOT_AHI] && sfr_wdata[CTL_REQ];

    sfr_bridge_fsm #(
        .RD_LAT (RD_LAT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .per_wr  (per_wr),
        .per_rd  (per_rd),
        .capture (capture),
        .busy    (busy)
    );

    sfr_bridge_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_wr    (sfr_wr),
        .slot_hit  (slot_hit),
        .sfr_wdata (sfr_wdata),
        .busy      (busy),
        .capture   (capture),
        .per_rdata (per_rdata),
        .addr_q    (per_addr),
        .wdata_q   (per_wdata),
        .sfr_rdata (sfr_rdata)
    );

endmodule

// File: rtl/sfr_bridge_checker.sv
module sfr_bridge_checker
    import sfr_bridge_pkg::*;
#(
    parameter int                    SFR_ADDR_W = 7,
    parameter logic [SFR_ADDR_W-1:0] SFR_BASE   = 7'h40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [SFR_ADDR_W-1:0] sfr_addr,
    input logic                  sfr_wr,
    input logic [DATA_W-1:0]     sfr_wdata,
    input logic [PER_ADDR_W-1:0] per_addr,
    input logic [DATA_W-1:0]     per_wdata,
    input logic                  per_wr,
    input logic                  per_rd,
    input logic                  busy
);

    localparam logic [SFR_ADDR_W-1:0] AHI_ADDR  = SFR_ADDR_W'(SFR_BASE + SLOT_AHI);
    localparam logic [SFR_ADDR_W-1:0] WDAT_ADDR = SFR_ADDR_W'(SFR_BASE + SLOT_WDAT);

    AST_WR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == WDAT_ADDR && !busy) |=> (per_wr && per_wdata == $past(sfr_wdata))); // R4

    AST_RD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == AHI_ADDR && sfr_wdata[CTL_REQ] && !busy) |=> per_rd); // R5

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && busy) |=> (!per_wr && !per_rd)); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(per_addr)); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(per_wr && per_rd)); // R10

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> !per_wr); // R10

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_rd |=> !per_rd); // R10

endmodule

bind sfr_ind_bridge sfr_bridge_checker #(
    .SFR_ADDR_W (SFR_ADDR_W),
    .SFR_BASE   (SFR_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .per_wr    (per_wr),
    .per_rd    (per_rd),
    .busy      (busy)
);

// File: tb/sfr_ind_bridge_test.sv
module sfr_ind_bridge_test;

    localparam int         RD_LAT = 3;
    localparam logic [6:0] BASE   = 7'h40;
    localparam logic [6:0] A_LO   = BASE;
    localparam logic [6:0] A_HI   = BASE + 7'd1;
    localparam logic [6:0] A_WD   = BASE + 7'd2;
    localparam logic [6:0] A_RD   = BASE + 7'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] sfr_addr = '0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic       sfr_hit;
    logic [8:0] per_addr;
    logic [7:0] per_wdata;
    logic       per_wr;
    logic       per_rd;
    logic [7:0] per_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sfr_ind_bridge #(.RD_LAT(RD_LAT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .sfr_hit   (sfr_hit),
        .per_addr  (per_addr),
        .per_wdata (per_wdata),
        .per_wr    (per_wr),
        .per_rd    (per_rd),
        .per_rdata (per_rdata)
    );

    // peripheral model: register file with fixed read latency
    logic [7:0] mem [512];
    logic [7:0] pipe [RD_LAT];
    assign per_rdata = pipe[RD_LAT-1];

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < RD_LAT; i++) pipe[i] = 8'hEE;
    end

    always @(posedge clk) begin
        if (per_wr) mem[per_addr] <= per_wdata;
        pipe[0] <= per_rd ? mem[per_addr] : 8'hEE;
        for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard of expected peripheral writes {addr, data}
    logic [16:0] exp_q [$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (per_wr && per_rd) check("R10", "both strobes high", 1, 0);
            if (per_wr) begin
                if (exp_q.size() == 0) begin
                    check("R4/R7", "unexpected write strobe", {15'd0, per_addr, per_wdata}, 0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check("R4", "write addr/data", {15'd0, per_addr, per_wdata}, {15'd0, e});
                end
            end
        end
    end

    task automatic sfr_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr  = a;
        sfr_wdata = d;
        sfr_wr    = 1'b1;
        @(negedge clk);
        sfr_wr    = 1'b0;
    endtask

    task automatic sfr_read(input logic [6:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic set_addr(input logic [8:0] a);
        sfr_write(A_LO, a[7:0]);
        sfr_write(A_HI, {7'd0, a[8]});
    endtask

    // driver: push expectation, then write data slot
    task automatic bridge_write(input logic [8:0] a, input logic [7:0] d);
        set_addr(a);
        exp_q.push_back({a, d});
        sfr_write(A_WD, d);
    endtask

    task automatic bridge_read(input logic [8:0] a, input bit intrude, output logic [7:0] got);
        logic [7:0] v;
        logic [7:0] wd_before;
        sfr_write(A_LO, a[7:0]);
        sfr_read(A_WD, wd_before);
        sfr_write(A_HI, {6'd0, 1'b1, a[8]});
        check("R5", "read strobe after request", per_rd, 1);
        check("R3", "address during read", per_addr, a);
        for (int k = 2; k <= RD_LAT + 2; k++) begin
            @(negedge clk);
            sfr_wr = 1'b0;
            check("R10", "read strobe single cycle", per_rd, 0);
            if (intrude && k == 2) begin
                sfr_addr  = A_WD;
                sfr_wdata = 8'h77;
                sfr_wr    = 1'b1;
            end else if (k == RD_LAT + 1) begin
                sfr_read(A_HI, v);
                check("R7", "busy on last busy cycle", v[2], 1);
                check("R6", "done low while busy", v[3], 0);
            end
        end
        sfr_read(A_HI, v);
        check("R7", "busy cleared after read", v[2], 0);
        check("R5", "done set after read", v[3], 1);
        check("R6", "status addr bit and zero bits", {v[7:4], v[1:0]}, {5'd0, a[8]});
        check("R7", "address held", per_addr, a);
        if (intrude) begin
            sfr_read(A_WD, v);
            check("R7", "write-data slot kept during busy", v, wd_before);
        end
        sfr_read(A_RD, got);
    endtask

    initial begin
        logic [7:0] v;
        logic [8:0] fa;
        #(8 * 60000);
        check("WDOG", "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
        v = 0; fa = 0;
    end

    initial begin
        logic [7:0] v;
        logic [8:0] fa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "per_addr", per_addr, 0);
        check("R1", "per_wdata", per_wdata, 0);
        check("R1", "strobes", {per_wr, per_rd}, 0);
        sfr_read(A_HI, v);  check("R1", "control slot", v, 0);
        sfr_read(A_RD, v);  check("R1", "read-data slot", v, 0);

        // R2 decode
        sfr_read(7'h3F, v); check("R2", "hit below range", sfr_hit, 0); check("R2", "rdata below", v, 0);
        sfr_read(7'h44, v); check("R2", "hit above range", sfr_hit, 0);
        sfr_read(A_LO, v);  check("R2", "hit at base", sfr_hit, 1);
        sfr_read(A_RD, v);  check("R2", "hit at base+3", sfr_hit, 1);
        sfr_write(7'h44, 8'h5A);
        sfr_write(7'h3F, 8'hC3);
        check("R2", "foreign writes leave address", per_addr, 0);
        check("R2", "foreign writes issue no strobe", {per_wr, per_rd}, 0);

        // R3 address assembly and field layout
        set_addr(9'h1A5);
        check("R3", "assembled address", per_addr, 9'h1A5);
        sfr_read(A_LO, v);  check("R3", "low slot readback", v, 8'hA5);
        fa = {4'd13, 1'b1, 2'd2, 2'd1};
        set_addr(fa);
        check("R3", "channel field", per_addr[8:5], 13);
        check("R3", "tx/rx field", per_addr[4], 1);
        check("R3", "register index field", per_addr[3:2], 2);
        check("R3", "byte index field", per_addr[1:0], 1);

        // R4 writes through scoreboard
        bridge_write(9'h000, 8'h11);
        bridge_write(9'h1FF, 8'hFE);
        bridge_write(9'h0C4, 8'h3C);
        bridge_write(fa, 8'h81);
        sfr_read(A_WD, v);  check("R4", "write-data slot readback", v, 8'h81);

        // R5 reads: fresh location and location just written
        bridge_read(9'h133, 1'b0, v);
        check("R5", "read data fresh location", v, 8'(9'h133 * 7 + 3));
        bridge_read(9'h0C4, 1'b0, v);
        check("R5", "read data after write", v, 8'h3C);

        // R7 write while busy is dropped
        bridge_read(9'h1FF, 1'b1, v);
        check("R5", "read with intrusion", v, 8'hFE);

        // R8 done cleared by a plain control write
        sfr_write(A_HI, 8'h01);
        sfr_read(A_HI, v);
        check("R8", "done cleared", v[3], 0);
        check("R8", "addr bit kept by control write", v[0], 1);

        // R9 read-data slot not writable
        sfr_read(A_RD, v);
        sfr_write(A_RD, ~v);
        begin
            logic [7:0] w;
            sfr_read(A_RD, w);
            check("R9", "read-data slot unchanged", w, v);
        end
        check("R9", "no strobe from slot 3 write", {per_wr, per_rd}, 0);

        repeat (4) @(negedge clk);
        check("R4", "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule